// File: doc/BRIEF.md
# Ramped Pulse Generator

This block drives a stepper-style motor interface with a square pulse train. The pulse rate moves gradually toward a programmed frequency instead of jumping to it. Software writes a control word, a 32-bit target frequency split over two 16-bit registers, and a slew rate. It then strobes `start`. The start is checked, and if accepted, the new settings become active at once.

A free-running divider produces a control tick every `TICK_CYCLES` clocks. The default is 4 ms at 200 MHz. On each tick the ramp engine moves its current frequency one rate step toward the target, and it lands exactly on the target on the final step.

A phase accumulator turns the current frequency into a 50% duty square wave. Two output pins carry that wave in one of two ways:
- **Separate-pin method:** the wave appears on one pin per direction.
- **Pulse+direction method:** the wave appears on `pin_a`, and `pin_b` gives the direction.

The ramp engine is a four-state machine:
- **ST_IDLE:** the frequency is zero and the target is zero.
- **ST_ACCEL:** the current frequency is below the target.
- **ST_CRUISE:** the current frequency equals a non-zero target.
- **ST_DECEL:** the current frequency is above the target.

The transitions are:
- **Load:** an accepted start picks ACCEL, DECEL, CRUISE or IDLE by comparing the new target with the current frequency. This is taken from any state.
- **Arrive-up (ACCEL → CRUISE):** taken on the tick where the remaining gap is at most one rate step.
- **Arrive-down (DECEL → CRUISE):** taken on the tick where the remaining gap is at most one rate step and the target is non-zero.
- **Stop (DECEL → IDLE):** taken on that same final tick when the target is zero.
- **Hold:** IDLE and CRUISE do not change on a tick.

Top module: `ramp_pulse_gen`

## Requirements
- R1: After reset, `cur_freq` is 0, `busy`, `cfg_err`, `pin_a` and `pin_b` are 0, and the active direction is CW with the separate-pin method.
- R2: Registers are selected by `wr_addr`:
  - Address 0 is the control word.
  - Address 1 is the low half of the target.
  - Address 2 is the high half of the target.
  - Address 3 is the rate.

  In the control word, bits 3:0 hold the mode (only 0, continuous, is accepted). Bits 7:4 hold the direction (0 = CW, 1 = CCW). Bits 11:8 hold the method (0 = separate pins, 1 = pulse+direction). Bits 15:12 must be 0. Register writes alone never change any output.
- R3: A start is rejected, setting `cfg_err` to 1, if any of these holds: the target exceeds 1,000,000, the rate is 0, or a control field is outside the values of R2. A rejected start leaves `cur_freq`, `busy` and the active settings unchanged. An accepted start clears `cfg_err`.
- R4: While below the target, each tick raises `cur_freq` by the rate, or sets it to the target when the gap is no larger than the rate.
- R5: While above the target, each tick lowers `cur_freq` by the rate, or sets it to the target when the gap is no larger than the rate.
- R6: `cur_freq` changes only on a tick, and ticks occur exactly every `TICK_CYCLES` clock cycles, independent of starts.
- R7: `busy` is 1 whenever `cur_freq` is non-zero or differs from the active target, and 0 otherwise.
- R8: At a steady `cur_freq` of f Hz, the active pin shows f·T/`CLK_HZ` rising edges (±1) over any T-cycle window, and is high about half the time.
- R9: With the separate-pin method, pulses appear only on `pin_a` for CW or only on `pin_b` for CCW, and the other pin stays 0.
- R10: With the pulse+direction method, pulses appear on `pin_a`, and `pin_b` is held at 1 for CCW and 0 for CW.
- R11: A target of 0 ramps the output down to 0. After that, both pins stop pulsing and `busy` drops.
- R12: A new accepted start while ramping continues from the present `cur_freq` toward the new target, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 target low, 2 target high, 3 rate) |
| wr_data | input | WORD_W | Register write data |
| start | input | 1 | Validate staged registers and make them active |
| pin_a | output | 1 | CW pulses, or pulses in pulse+direction method |
| pin_b | output | 1 | CCW pulses, or direction level in pulse+direction method |
| cur_freq | output | 2*WORD_W | Present output frequency in Hz |
| busy | output | 1 | Output running or still ramping |
| cfg_err | output | 1 | Last start was rejected |

## Verification
The assertions take several things for granted:
- `start` and `wr_en` are never raised in the same cycle.
- The registers are stable while `start` is high.
- A start has priority over a tick in the same cycle.

Under these conditions, the step-size and no-overshoot properties can compare each change of `cur_freq` with the rate and target that were active one cycle earlier.

The stimulus keeps within these limits:
- Every register access and every start is a separate single-cycle strobe driven at the falling edge.
- The re-target test issues its start just after an observed step, so it never lands on a tick.
- Targets stay within the accepted range except in the vectors that exercise rejection.

// File: rtl/rpg_pkg.sv
`timescale 1ns/1ps
package rpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEL  = 2'd1,
        ST_CRUISE = 2'd2,
        ST_DECEL  = 2'd3
    } ramp_state_e;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_TGT_LO = 2'd1;
    localparam logic [1:0] REG_TGT_HI = 2'd2;
    localparam logic [1:0] REG_RATE   = 2'd3;

endpackage

// File: rtl/rpg_tick.sv
`timescale 1ns/1ps
module rpg_tick #(
    parameter int TICK_CYCLES = 800_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(TICK_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= (cnt_q == LAST);
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rpg_ramp.sv
`timescale 1ns/1ps
module rpg_ramp
    import rpg_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [FREQ_W-1:0] load_tgt,
    input  logic [RATE_W-1:0] load_rate,
    output logic [FREQ_W-1:0] cur_freq,
    output logic [FREQ_W-1:0] tgt_freq,
    output logic [RATE_W-1:0] rate,
    output logic              busy
);
    localparam int PAD_W = FREQ_W - RATE_W;

    ramp_state_e       st_q, st_d;
    logic [FREQ_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
    logic [RATE_W-1:0] rate_q, rate_d;
    logic [FREQ_W-1:0] step, gap_up, gap_dn;

    function automatic ramp_state_e pick_state(input logic [FREQ_W-1:0] cur,
                                               input logic [FREQ_W-1:0] tgt);
        if (tgt > cur)       return ST_ACCEL;
        else if (tgt < cur)  return ST_DECEL;
        else if (tgt == '0)  return ST_IDLE;
        else                 return ST_CRUISE;
    endfunction

    assign step   = {{PAD_W{1'b0}}, rate_q};
    assign gap_up = tgt_q - cur_q;
    assign gap_dn = cur_q - tgt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            tgt_q  <= '0;
            rate_q <= '0;
        end else begin
            st_q   <= st_d;
            cur_q  <= cur_d;
            tgt_q  <= tgt_d;
            rate_q <= rate_d;
        end
    end

    // next state and next frequency
    always_comb begin
        st_d   = st_q;
        cur_d  = cur_q;
        tgt_d  = tgt_q;
        rate_d = rate_q;
        if (load) begin
            tgt_d  = load_tgt;
            rate_d = load_rate;
            st_d   = pick_state(cur_q, load_tgt);
        end else if (tick) begin
            unique case (st_q)
                ST_IDLE, ST_CRUISE: begin
                    st_d = st_q;
                end
                ST_ACCEL: begin
                    if (gap_up <= step) begin
                        cur_d = tgt_q;
                        st_d  = ST_CRUISE;
                    end else begin
                        cur_d = cur_q + step;
                    end
                end
                ST_DECEL: begin
                    if (gap_dn <= step) begin
                        cur_d = tgt_q;
                        st_d  = (tgt_q == '0) ? ST_IDLE : ST_CRUISE;
                    end else begin
                        cur_d = cur_q - step;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cur_freq = cur_q;
        tgt_freq = tgt_q;
        rate     = rate_q;
        busy     = (cur_q != tgt_q) || (cur_q != '0);
    end
endmodule

// File: rtl/rpg_nco.sv
`timescale 1ns/1ps
module rpg_nco #(
    parameter int CLK_HZ  = 200_000_000,
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 32,
    parameter int FRAC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq,
    output logic              wave
);
    localparam logic [63:0] INC_K =
        ((64'd1 << (PHASE_W + FRAC_W)) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);

    logic [PHASE_W-1:0] inc, phase_q;

    assign inc = PHASE_W'((64'(freq) * INC_K) >> FRAC_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase_q <= '0;
        else if (freq == '0)    phase_q <= '0;
        else                    phase_q <= phase_q + inc;
    end

    assign wave = phase_q[PHASE_W-1];
endmodule

// File: rtl/rpg_pinmap.sv
`timescale 1ns/1ps
module rpg_pinmap (
    input  logic clk,
    input  logic rst_n,
    input  logic wave,
    input  logic dir_ccw,
    input  logic pulse_dir,
    output logic pin_a,
    output logic pin_b
);
    logic a_d, b_d;

    always_comb begin
        if (pulse_dir) begin
            a_d = wave;
            b_d = dir_ccw;
        end else begin
            a_d = wave & ~dir_ccw;
            b_d = wave &  dir_ccw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_a <= 1'b0;
            pin_b <= 1'b0;
        end else begin
            pin_a <= a_d;
            pin_b <= b_d;
        end
    end
endmodule

// File: rtl/ramp_pulse_gen.sv
`timescale 1ns/1ps
module ramp_pulse_gen
    import rpg_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int TICK_CYCLES = 800_000,
    parameter int WORD_W      = 16,
    parameter int F_MAX       = 1_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                start,
    output logic                pin_a,
    output logic                pin_b,
    output logic [2*WORD_W-1:0] cur_freq,
    output logic                busy,
    output logic                cfg_err
);
    localparam int FREQ_W = 2 * WORD_W;

    logic [WORD_W-1:0] ctrl_q, tlo_q, thi_q, rate_q;
    logic [FREQ_W-1:0] tgt_stage, act_tgt;
    logic [WORD_W-1:0] act_rate;
    logic              dir_q, meth_q, err_q;
    logic              tick_w, wave_w, cfg_ok, load;

    // staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tlo_q  <= '0;
            thi_q  <= '0;
            rate_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL:   ctrl_q <= wr_data;
                REG_TGT_LO: tlo_q  <= wr_data;
                REG_TGT_HI: thi_q  <= wr_data;
                REG_RATE:   rate_q <= wr_data;
            endcase
        end
    end

    assign tgt_stage = {thi_q, tlo_q};

    always_comb begin
        cfg_ok = (ctrl_q[3:0]   == 4'd0)
              && (ctrl_q[7:4]   <= 4'd1)
              && (ctrl_q[11:8]  <= 4'd1)
              && (ctrl_q[15:12] == 4'd0)
              && (tgt_stage <= FREQ_W'(F_MAX))
              && (rate_q != '0);
    end

    assign load = start & cfg_ok;

    // active settings and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            meth_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            if (cfg_ok) begin
                dir_q  <= ctrl_q[4];
                meth_q <= ctrl_q[8];
                err_q  <= 1'b0;
            end else begin
                err_q  <= 1'b1;
            end
        end
    end

    rpg_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    rpg_ramp #(.FREQ_W(FREQ_W), .RATE_W(WORD_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .load     (load),
        .load_tgt (tgt_stage),
        .load_rate(rate_q),
        .cur_freq (cur_freq),
        .tgt_freq (act_tgt),
        .rate     (act_rate),
        .busy     (busy)
    );

    rpg_nco #(.CLK_HZ(CLK_HZ), .FREQ_W(FREQ_W)) u_nco (
        .clk  (clk),
        .rst_n(rst_n),
        .freq (cur_freq),
        .wave (wave_w)
    );

    rpg_pinmap u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .wave     (wave_w),
        .dir_ccw  (dir_q),
        .pulse_dir(meth_q),
        .pin_a    (pin_a),
        .pin_b    (pin_b)
    );

    assign cfg_err = err_q;
endmodule

// File: rtl/rpg_chk.sv
`timescale 1ns/1ps
module rpg_chk #(
    parameter int FREQ_W = 32,
    parameter int RATE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [FREQ_W-1:0] cur_freq,
    input logic [FREQ_W-1:0] tgt,
    input logic [RATE_W-1:0] rate,
    input logic              meth,
    input logic              pin_a,
    input logic              pin_b,
    input logic              busy,
    input logic              cfg_err
);
    logic [FREQ_W-1:0] rate_ext;
    assign rate_ext = {{(FREQ_W-RATE_W){1'b0}}, rate};

    // R6
    cur_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_freq != $past(cur_freq)) |-> $past(tick));

    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_freq != $past(cur_freq)) |->
        (((cur_freq > $past(cur_freq)) ? (cur_freq - $past(cur_freq))
                                       : ($past(cur_freq) - cur_freq)) <= $past(rate_ext)));

    // R5
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_freq != $past(cur_freq)) |->
        (($past(cur_freq) < $past(tgt)) ? (cur_freq <= $past(tgt))
                                        : (cur_freq >= $past(tgt))));

    // R9
    one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(meth)) |-> !(pin_a && pin_b));

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> ($stable(cur_freq) && $stable(tgt)));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (cur_freq == '0));
endmodule

bind ramp_pulse_gen rpg_chk #(.FREQ_W(2*WORD_W), .RATE_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .cur_freq(cur_freq),
    .tgt     (act_tgt),
    .rate    (act_rate),
    .meth    (meth_q),
    .pin_a   (pin_a),
    .pin_b   (pin_b),
    .busy    (busy),
    .cfg_err (cfg_err)
);

// File: tb/tb_ramp_pulse_gen.sv
`timescale 1ns/1ps
module tb_ramp_pulse_gen;
    localparam int TICK   = 40;
    localparam int CLK_HZ = 200_000_000;
    localparam int WIN    = 4000;
    localparam int NVEC   = 9;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [31:0] tgt;
        logic [15:0] rate;
        logic        rej;
    } vec_t;

    // control word: [3:0] mode, [7:4] dir, [11:8] method (R2)
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 32'd500000,  16'd65535, 1'b0},   // CW separate, accel
        '{16'h0010, 32'd1000000, 16'd40000, 1'b0},   // CCW separate, accel clamp
        '{16'h0110, 32'd1000000, 16'd5,     1'b0},   // CCW pulse+dir, cruise
        '{16'h0000, 32'd1000001, 16'd5,     1'b1},   // target too high
        '{16'h0100, 32'd250000,  16'd0,     1'b1},   // rate zero
        '{16'h0001, 32'd250000,  16'd10,    1'b1},   // mode not continuous
        '{16'h0200, 32'd250000,  16'd10,    1'b1},   // method out of range
        '{16'h0100, 32'd200000,  16'd65535, 1'b0},   // CW pulse+dir, decel
        '{16'h0000, 32'd0,       16'd50000, 1'b0}    // stop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        start = 1'b0;
    logic        pin_a, pin_b, busy, cfg_err;
    logic [31:0] cur_freq;

    int     total = 0;
    int     bad = 0;
    longint cyc = 0;
    longint last_chg = -1;
    longint exp_cur = 0, exp_tgt = 0, exp_rate = 0;
    bit     exp_dir = 1'b0, exp_meth = 1'b0;
    vec_t   v;
    int     ea, eb, ha, hb;

    ramp_pulse_gen #(.CLK_HZ(CLK_HZ), .TICK_CYCLES(TICK)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .start   (start),
        .pin_a   (pin_a),
        .pin_b   (pin_b),
        .cur_freq(cur_freq),
        .busy    (busy),
        .cfg_err (cfg_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint nstep(input longint cur, input longint tgt, input longint rate);
        if (cur < tgt)      return (tgt - cur <= rate) ? tgt : cur + rate;
        else if (cur > tgt) return (cur - tgt <= rate) ? tgt : cur - rate;
        else                return cur;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_change(output bit ok);
        logic [31:0] prev;
        int n;
        prev = cur_freq;
        n = 0;
        while (cur_freq == prev && n < 4 * TICK) begin
            @(negedge clk);
            n++;
        end
        ok = (cur_freq != prev);
    endtask

    task automatic one_step();
        longint nxt;
        bit ok;
        nxt = nstep(exp_cur, exp_tgt, exp_rate);
        wait_change(ok);
        if (!ok) begin
            chk(1'b0, "R6 step timeout", cur_freq, nxt);
            return;
        end
        if (nxt > exp_cur) chk(cur_freq == nxt, "R4", cur_freq, nxt);
        else               chk(cur_freq == nxt, "R5", cur_freq, nxt);
        if (last_chg >= 0)
            chk(((cyc - last_chg) % TICK) == 0, "R6", cyc - last_chg, TICK);
        last_chg = cyc;
        exp_cur = nxt;
    endtask

    task automatic ramp_to();
        while (exp_cur != exp_tgt && bad < 20) one_step();
    endtask

    task automatic measure();
        logic pa, pb;
        ea = 0; eb = 0; ha = 0; hb = 0;
        pa = pin_a; pb = pin_b;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (pin_a && !pa) ea++;
            if (pin_b && !pb) eb++;
            ha += int'(pin_a);
            hb += int'(pin_b);
            pa = pin_a; pb = pin_b;
        end
    endtask

    task automatic check_pins();
        longint exp_e;
        int act_e, act_h, oth_h;
        exp_e = exp_cur * WIN / CLK_HZ;
        repeat (4) @(negedge clk);
        measure();
        if (exp_meth || !exp_dir) begin
            act_e = ea; act_h = ha; oth_h = hb;
        end else begin
            act_e = eb; act_h = hb; oth_h = ha;
        end
        if (exp_cur == 0) begin
            // R11: stopped output, no pulses
            chk(ea == 0 && eb == 0, "R11 pulses", ea + eb, 0);
            chk(busy == 1'b0, "R11 busy", busy, 0);
        end else begin
            // R8: rate and duty
            chk(act_e >= exp_e - 1 && act_e <= exp_e + 1, "R8 edges", act_e, exp_e);
            chk(act_h >= WIN * 3 / 8 && act_h <= WIN * 5 / 8, "R8 duty", act_h, WIN / 2);
        end
        if (exp_meth) chk(oth_h == (exp_dir ? WIN : 0), "R10 dir pin", oth_h, exp_dir ? WIN : 0);
        else          chk(oth_h == 0, "R9 idle pin", oth_h, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cur_freq == 0, "R1 cur_freq", cur_freq, 0);
        chk(!busy && !cfg_err, "R1 flags", {busy, cfg_err}, 0);
        chk(!pin_a && !pin_b, "R1 pins", {pin_a, pin_b}, 0);

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            wr(2'd0, v.ctrl);
            wr(2'd1, v.tgt[15:0]);
            wr(2'd2, v.tgt[31:16]);
            wr(2'd3, v.rate);
            // R2: writes alone change nothing
            chk(cur_freq == exp_cur[31:0], "R2 no effect", cur_freq, exp_cur);
            do_start();
            chk(cfg_err == v.rej, "R3 err flag", cfg_err, v.rej);
            if (v.rej) begin
                repeat (2 * TICK) @(negedge clk);
                chk(cur_freq == exp_cur[31:0], "R3 held", cur_freq, exp_cur);
                chk(busy == (exp_cur != 0 || exp_cur != exp_tgt), "R3 busy held", busy, 1);
            end else begin
                exp_tgt = v.tgt; exp_rate = v.rate;
                exp_dir = v.ctrl[4]; exp_meth = v.ctrl[8];
                if (exp_cur != exp_tgt)
                    chk(busy == 1'b1, "R7 busy ramp", busy, 1);
                ramp_to();
                chk(busy == (exp_tgt != 0), "R7 busy settled", busy, exp_tgt != 0);
                check_pins();
            end
        end

        // R12: re-target mid-ramp
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd34464);      // 100000 low half
        wr(2'd2, 16'd1);
        wr(2'd3, 16'd10000);
        do_start();
        exp_tgt = 100000; exp_rate = 10000; exp_dir = 1'b0; exp_meth = 1'b0;
        for (int k = 0; k < 3; k++) one_step();
        wr(2'd1, 16'd15000);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd6000);
        do_start();
        chk(cur_freq == 32'd30000, "R12 no jump", cur_freq, 30000);
        chk(!cfg_err, "R12 accepted", cfg_err, 0);
        exp_tgt = 15000; exp_rate = 6000;
        ramp_to();
        chk(cur_freq == 32'd15000, "R12 final", cur_freq, 15000);

        // R1: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cur_freq == 0 && !busy, "R1 mid reset", cur_freq, 0);
        chk(!pin_a && !pin_b, "R1 mid reset pins", {pin_a, pin_b}, 0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule